// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is a small DMA controller with eight independent channels that share one memory port. Each channel is started by a request line from an on-chip peripheral. It copies data units of 8, 16 or 32 bits from a source address to a destination address. Every unit is one read cycle followed by one write cycle on the memory port. Before a channel is enabled, its source, destination, unit count, block length and control word are loaded through a single configuration write port.

Each channel picks one of four service patterns:
- **Step:** one unit per trigger.
- **Block:** a programmed number of units per trigger.
- **Burst:** the whole remaining count on one trigger.
- **Continuous:** units keep moving for as long as the request line stays high.

When several channels are ready together, the lowest channel number is served first. A separate pause input stands for a higher-priority interrupt. It parks the engine between units and releases it later with the channel context intact. When a channel's count runs out, it sets a sticky done flag, drops its own enable, and the combined interrupt output goes high.

Top module: `dma_engine`

## Requirements
- R1: After reset, mem_rd, mem_wr, every done_o bit and irq_o are 0, and no memory cycle occurs until a channel is configured and triggered.
- R2: In step mode (control bits [4:3] = 0), each rising edge on the channel's request moves exactly one unit.
- R3: In block mode (control bits [4:3] = 1), each rising edge on the request moves the number of units held in bits [31:16] of the count register, or fewer if the count runs out first.
- R4: In burst mode (control bits [4:3] = 2), a single rising edge on the request moves every remaining unit.
- R5: In continuous mode (control bits [4:3] = 3), units keep moving while the request is high. Transfer stops within one unit after the request falls and resumes when it rises again.
- R6: Control bits [2:1] select the unit size: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. mem_size carries that code (never 3) on every memory cycle. Data is right-aligned on mem_rdata and mem_wdata, with the byte at the lowest address in bits [7:0].
- R7: Control bit 5 (source) and bit 6 (destination) select whether an address advances by the unit size in bytes after each unit or stays fixed.
- R8: When the unit count (count register bits [15:0]) reaches zero, the channel sets its done_o bit and clears its enable. Later requests on that channel move nothing until it is reconfigured. Writing its control register clears done_o.
- R9: When several channels become ready in the same cycle, the lowest-numbered channel is served first.
- R10: While pause_i is high, no new read starts. A channel stopped mid-sequence resumes with its next unit after pause_i falls, and no unit is lost or repeated.
- R11: Every write cycle directly follows a read cycle, and read and write are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | $clog2(NCH) | Channel selected by the write |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count/block length, 3 control |
| cfg_wdata | input | 32 | Configuration write data |
| req_i | input | NCH | Peripheral request lines, one per channel |
| pause_i | input | 1 | Higher-priority interrupt; holds the engine between units |
| mem_rd | output | 1 | Memory read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Byte address of the current cycle |
| mem_size | output | 2 | Unit size code of the current cycle |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned, valid one cycle after mem_rd |
| done_o | output | NCH | Sticky completion flag per channel |
| irq_o | output | 1 | OR of all done flags |

## Verification
Stimulus per service pattern:
- Step and block channels get isolated single-cycle request pulses. The unit count after each pulse separates one unit, one block and the whole count.
- A burst channel gets one pulse. Its full transfer shows that a lone trigger drains the count.
- A continuous channel gets a held request that is then dropped. The write count freezing after the drop separates level-following from edge-triggered behaviour.

Size and address handling:
- Byte, halfword and word transfers check byte order and address step.
- Fixed-source and fixed-destination transfers show the address holding still.

Arbitration and pause:
- Two channels triggered in the same cycle expose the arbitration order.
- Pausing a burst mid-way and releasing it shows that the context survives the pause and no unit is lost or repeated.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        XM_STEP  = 2'd0,
        XM_BLOCK = 2'd1,
        XM_BURST = 2'd2,
        XM_CONT  = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_HOLD  = 2'd3
    } seq_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int BLK_LSB = 16;

endpackage

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
    import dma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CHW-1:0]      cfg_ch,
    input  logic [1:0]          cfg_sel,
    input  logic [31:0]         cfg_wdata,
    input  logic [NCH-1:0]      req_i,
    input  logic [NCH-1:0]      grant_clr,
    input  logic                wb_en,
    input  logic [CHW-1:0]      wb_ch,
    input  logic [AW-1:0]       wb_src,
    input  logic [AW-1:0]       wb_dst,
    input  logic [CW-1:0]       wb_cnt,
    input  logic                wb_last,
    output logic [AW-1:0]       src_o [NCH],
    output logic [AW-1:0]       dst_o [NCH],
    output logic [CW-1:0]       cnt_o [NCH],
    output logic [CW-1:0]       blk_o [NCH],
    output xfer_size_e          size_o [NCH],
    output xfer_mode_e          mode_o [NCH],
    output logic [NCH-1:0]      sinc_o,
    output logic [NCH-1:0]      dinc_o,
    output logic [NCH-1:0]      en_o,
    output logic [NCH-1:0]      pend_o,
    output logic [NCH-1:0]      done_o
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [CW-1:0] blk;
        xfer_size_e    size;
        xfer_mode_e    mode;
        logic          sinc;
        logic          dinc;
        logic          en;
        logic          pend;
        logic          done;
        logic          req_q;
    } chan_t;

    chan_t ch_d [NCH];
    chan_t ch_q [NCH];

    logic cfg_unused;
    assign cfg_unused = ^cfg_wdata;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_d[i]       = ch_q[i];
            ch_d[i].req_q = req_i[i];
            if (grant_clr[i]) ch_d[i].pend = 1'b0;
            if (req_i[i] && !ch_q[i].req_q && ch_q[i].en) ch_d[i].pend = 1'b1;
            if (cfg_we && cfg_ch == CHW'(i)) begin
                case (cfg_sel)
                    SEL_SRC: ch_d[i].src = cfg_wdata[AW-1:0];
                    SEL_DST: ch_d[i].dst = cfg_wdata[AW-1:0];
                    SEL_CNT: begin
                        ch_d[i].cnt = cfg_wdata[CW-1:0];
                        ch_d[i].blk = cfg_wdata[BLK_LSB +: CW];
                    end
                    default: begin
                        ch_d[i].en   = cfg_wdata[0];
                        ch_d[i].size = xfer_size_e'(cfg_wdata[2:1]);
                        ch_d[i].mode = xfer_mode_e'(cfg_wdata[4:3]);
                        ch_d[i].sinc = cfg_wdata[5];
                        ch_d[i].dinc = cfg_wdata[6];
                        ch_d[i].done = 1'b0;
                        ch_d[i].pend = 1'b0;
                    end
                endcase
            end
            if (wb_en && wb_ch == CHW'(i)) begin
                ch_d[i].src = wb_src;
                ch_d[i].dst = wb_dst;
                ch_d[i].cnt = wb_cnt;
                if (wb_last) begin
                    ch_d[i].en   = 1'b0;
                    ch_d[i].done = 1'b1;
                    ch_d[i].pend = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) ch_q[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) ch_q[i] <= ch_d[i];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign src_o[g]  = ch_q[g].src;
        assign dst_o[g]  = ch_q[g].dst;
        assign cnt_o[g]  = ch_q[g].cnt;
        assign blk_o[g]  = ch_q[g].blk;
        assign size_o[g] = ch_q[g].size;
        assign mode_o[g] = ch_q[g].mode;
        assign sinc_o[g] = ch_q[g].sinc;
        assign dinc_o[g] = ch_q[g].dinc;
        assign en_o[g]   = ch_q[g].en;
        assign pend_o[g] = ch_q[g].pend;
        assign done_o[g] = ch_q[g].done;
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig,
    output logic           gnt_vld,
    output logic [CHW-1:0] gnt_idx
);

    always_comb begin
        gnt_vld = |elig;
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) gnt_idx = CHW'(i);
        end
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  xfer_size_e    size,
    input  logic          inc,
    output logic [AW-1:0] nxt
);

    logic [2:0] nbytes;

    always_comb begin
        case (size)
            SZ_BYTE: nbytes = 3'd1;
            SZ_HALF: nbytes = 3'd2;
            default: nbytes = 3'd4;
        endcase
        nxt = inc ? addr + AW'(nbytes) : addr;
    end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    input  logic [NCH-1:0]  req_i,
    input  logic            pause_i,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    output logic [NCH-1:0]  done_o,
    output logic            irq_o
);

    typedef struct packed {
        seq_state_e     st;
        logic [CHW-1:0] ch;
        logic [CW-1:0]  left;
    } seq_t;

    seq_t sq_d, sq_q;

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [CW-1:0]  blk_a [NCH];
    xfer_size_e     size_a [NCH];
    xfer_mode_e     mode_a [NCH];
    logic [NCH-1:0] sinc_a, dinc_a, en_a, pend_a, elig;

    logic [NCH-1:0] grant_clr;
    logic           wb_en, wb_last;
    logic [AW-1:0]  src_nxt, dst_nxt;
    logic [CW-1:0]  cnt_nxt;
    logic           gnt_vld;
    logic [CHW-1:0] gnt_idx;

    logic [AW-1:0]  cur_src, cur_dst;
    logic [CW-1:0]  cur_cnt;
    xfer_size_e     cur_size;
    xfer_mode_e     cur_mode;

    dma_chan_bank #(.NCH(NCH), .AW(AW), .CW(CW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req_i     (req_i),
        .grant_clr (grant_clr),
        .wb_en     (wb_en),
        .wb_ch     (sq_q.ch),
        .wb_src    (src_nxt),
        .wb_dst    (dst_nxt),
        .wb_cnt    (cnt_nxt),
        .wb_last   (wb_last),
        .src_o     (src_a),
        .dst_o     (dst_a),
        .cnt_o     (cnt_a),
        .blk_o     (blk_a),
        .size_o    (size_a),
        .mode_o    (mode_a),
        .sinc_o    (sinc_a),
        .dinc_o    (dinc_a),
        .en_o      (en_a),
        .pend_o    (pend_a),
        .done_o    (done_o)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_elig
        assign elig[g] = en_a[g] & (pend_a[g] | ((mode_a[g] == XM_CONT) & req_i[g]));
    end

    dma_prio_arb #(.NCH(NCH)) u_arb (
        .elig    (elig),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    assign cur_src  = src_a[sq_q.ch];
    assign cur_dst  = dst_a[sq_q.ch];
    assign cur_cnt  = cnt_a[sq_q.ch];
    assign cur_size = size_a[sq_q.ch];
    assign cur_mode = mode_a[sq_q.ch];
    assign cnt_nxt  = cur_cnt - 1'b1;

    dma_addr_step #(.AW(AW)) u_src_step (
        .addr (cur_src),
        .size (cur_size),
        .inc  (sinc_a[sq_q.ch]),
        .nxt  (src_nxt)
    );

    dma_addr_step #(.AW(AW)) u_dst_step (
        .addr (cur_dst),
        .size (cur_size),
        .inc  (dinc_a[sq_q.ch]),
        .nxt  (dst_nxt)
    );

    always_comb begin
        logic          more;
        logic [CW-1:0] left_n;
        sq_d      = sq_q;
        grant_clr = '0;
        wb_en     = 1'b0;
        wb_last   = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        more      = 1'b0;
        left_n    = sq_q.left - 1'b1;
        case (sq_q.st)
            SQ_IDLE: begin
                if (gnt_vld && !pause_i) begin
                    sq_d.ch            = gnt_idx;
                    sq_d.left          = blk_a[gnt_idx];
                    sq_d.st            = SQ_READ;
                    grant_clr[gnt_idx] = 1'b1;
                end
            end
            SQ_READ: begin
                mem_rd  = 1'b1;
                sq_d.st = SQ_WRITE;
            end
            SQ_WRITE: begin
                mem_wr    = 1'b1;
                wb_en     = 1'b1;
                wb_last   = (cur_cnt <= CW'(1));
                sq_d.left = left_n;
                case (cur_mode)
                    XM_STEP:  more = 1'b0;
                    XM_BLOCK: more = (left_n != '0);
                    XM_BURST: more = 1'b1;
                    default:  more = req_i[sq_q.ch];
                endcase
                if (wb_last || !more) sq_d.st = SQ_IDLE;
                else if (pause_i)     sq_d.st = SQ_HOLD;
                else                  sq_d.st = SQ_READ;
            end
            default: begin
                if (!pause_i) sq_d.st = SQ_READ;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, ch: '0, left: '0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign mem_addr  = (sq_q.st == SQ_WRITE) ? cur_dst : cur_src;
    assign mem_size  = (cur_size == SZ_RSVD) ? 2'(SZ_WORD) : 2'(cur_size);
    assign mem_wdata = mem_rdata;
    assign irq_o     = |done_o;

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pause_i,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic [1:0]     mem_size,
    input logic [NCH-1:0] done_o
);

    a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r11_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r11_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    a_r10_no_read_after_pause: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !$past(pause_i));

    a_r8_done_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_o & ~$past(done_o)) != '0) |-> $past(mem_wr));

    a_r6_size_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_size != 2'd3));

endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pause_i  (pause_i),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_size (mem_size),
    .done_o   (done_o)
);

// File: tb/dma_engine_tb.sv
`timescale 1ns/1ps
module dma_engine_tb;

    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int CHW = 3;
    localparam int MSZ = 1024;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CHW-1:0]  cfg_ch = '0;
    logic [1:0]      cfg_sel = '0;
    logic [31:0]     cfg_wdata = '0;
    logic [NCH-1:0]  req_i = '0;
    logic            pause_i = 1'b0;
    logic            mem_rd, mem_wr;
    logic [AW-1:0]   mem_addr;
    logic [1:0]      mem_size;
    logic [31:0]     mem_wdata;
    logic [31:0]     mem_rdata = '0;
    logic [NCH-1:0]  done_o;
    logic            irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_engine #(.NCH(NCH), .AW(AW), .CW(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_i(req_i),
        .pause_i(pause_i), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done_o(done_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 13 + 7) ^ (a >> 3));
    endfunction

    // memory model and bus monitor
    logic [7:0]  mem [MSZ];
    int          wr_cnt = 0;
    int          seq_err = 0;
    logic [15:0] wr_log [256];
    logic        prev_rd = 1'b0;

    always @(posedge clk) begin
        int nb;
        logic [31:0] t;
        nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
        if (!rst_n) begin
            for (int i = 0; i < MSZ; i++) mem[i] <= pat(i);
        end else begin
            if (mem_rd) begin
                t = '0;
                for (int b = 0; b < 4; b++)
                    if (b < nb) t[8*b +: 8] = mem[(int'(mem_addr) + b) % MSZ];
                mem_rdata <= t;
            end
            if (mem_wr) begin
                for (int b = 0; b < 4; b++)
                    if (b < nb) mem[(int'(mem_addr) + b) % MSZ] <= mem_wdata[8*b +: 8];
                if (!prev_rd) seq_err <= seq_err + 1;
                wr_log[wr_cnt % 256] <= mem_addr;
                wr_cnt <= wr_cnt + 1;
            end
        end
        prev_rd <= mem_rd;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_wr(input int ch, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // control word: en bit0, size [2:1], mode [4:3], src inc bit5, dst inc bit6
    function automatic logic [31:0] ctl(input int sz, input int md, input bit si, input bit di);
        return {25'd0, di, si, 2'(md), 2'(sz), 1'b1};
    endfunction

    task automatic setup(input int ch, input int src, input int dst, input int cnt,
                         input int blk, input logic [31:0] c);
        cfg_wr(ch, 2'd0, 32'(src));
        cfg_wr(ch, 2'd1, 32'(dst));
        cfg_wr(ch, 2'd2, {16'(blk), 16'(cnt)});
        cfg_wr(ch, 2'd3, c);
    endtask

    task automatic pulse(input int ch);
        @(negedge clk);
        req_i[ch] = 1'b1;
        @(negedge clk);
        req_i[ch] = 1'b0;
    endtask

    function automatic int cmp_bytes(input int src, input int dst, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[dst + i] !== pat(src + i)) bad++;
        return bad;
    endfunction

    task automatic t_reset();
        check("R1 mem_rd", 32'(mem_rd), 0);
        check("R1 mem_wr", 32'(mem_wr), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 irq", 32'(irq_o), 0);
        wait_cyc(10);
        check("R1 no bus cycles", wr_cnt, 0);
    endtask

    task automatic t_step();
        int base;
        setup(2, 'h100, 'h200, 3, 0, ctl(0, 0, 1, 1));
        base = wr_cnt;
        pulse(2); wait_cyc(10);
        check("R2 one unit per trigger", wr_cnt - base, 1);
        check("R2 first byte", 32'(mem['h200]), 32'(pat('h100)));
        pulse(2); wait_cyc(10);
        pulse(2); wait_cyc(10);
        check("R2 three triggers", wr_cnt - base, 3);
        check("R2 data", cmp_bytes('h100, 'h200, 3), 0);
        check("R8 done set", 32'(done_o[2]), 1);
        check("R8 irq", 32'(irq_o), 1);
        pulse(2); wait_cyc(10);
        check("R8 disabled after count", wr_cnt - base, 3);
        check("R8 byte past end untouched", 32'(mem['h203]), 32'(pat('h203)));
        cfg_wr(2, 2'd3, 32'h0);
        check("R8 done cleared by control write", 32'(done_o[2]), 0);
    endtask

    task automatic t_block();
        int base;
        setup(3, 'h120, 'h240, 6, 2, ctl(1, 1, 1, 1));
        base = wr_cnt;
        pulse(3); wait_cyc(12);
        check("R3 block of two", wr_cnt - base, 2);
        check("R6 halfword data", cmp_bytes('h120, 'h240, 4), 0);
        check("R3 not done", 32'(done_o[3]), 0);
        pulse(3); wait_cyc(12);
        pulse(3); wait_cyc(12);
        check("R3 three blocks", wr_cnt - base, 6);
        check("R6 halfword all", cmp_bytes('h120, 'h240, 12), 0);
        check("R3 done", 32'(done_o[3]), 1);
    endtask

    task automatic t_burst();
        int base;
        setup(4, 'h140, 'h280, 4, 0, ctl(2, 2, 1, 1));
        base = wr_cnt;
        pulse(4); wait_cyc(20);
        check("R4 whole count on one trigger", wr_cnt - base, 4);
        check("R6 word data", cmp_bytes('h140, 'h280, 16), 0);
        check("R4 done", 32'(done_o[4]), 1);
    endtask

    task automatic t_fixed();
        setup(7, 'h160, 'h2C0, 3, 0, ctl(1, 2, 1, 0));
        pulse(7); wait_cyc(16);
        check("R7 fixed dst holds last unit", cmp_bytes('h164, 'h2C0, 2), 0);
        check("R7 fixed dst no spill", 32'(mem['h2C2]), 32'(pat('h2C2)));
        setup(6, 'h170, 'h2D0, 3, 0, ctl(0, 2, 0, 1));
        pulse(6); wait_cyc(16);
        check("R7 fixed src byte0", 32'(mem['h2D0]), 32'(pat('h170)));
        check("R7 fixed src byte2", 32'(mem['h2D2]), 32'(pat('h170)));
    endtask

    task automatic t_cont();
        int base, n1;
        setup(5, 'h180, 'h300, 40, 0, ctl(0, 3, 1, 1));
        base = wr_cnt;
        @(negedge clk); req_i[5] = 1'b1;
        wait_cyc(10);
        req_i[5] = 1'b0;
        wait_cyc(6);
        n1 = wr_cnt - base;
        check("R5 moved while held", 32'(n1 >= 2 && n1 < 40), 1);
        wait_cyc(20);
        check("R5 stops after drop", wr_cnt - base, n1);
        check("R5 not done", 32'(done_o[5]), 0);
        req_i[5] = 1'b1;
        wait_cyc(100);
        req_i[5] = 1'b0;
        check("R5 completes while held", wr_cnt - base, 40);
        check("R5 data", cmp_bytes('h180, 'h300, 40), 0);
        check("R5 done", 32'(done_o[5]), 1);
    endtask

    task automatic t_prio();
        int base;
        setup(6, 'h1B0, 'h350, 1, 0, ctl(0, 0, 1, 1));
        setup(1, 'h1A0, 'h340, 1, 0, ctl(0, 0, 1, 1));
        base = wr_cnt;
        @(negedge clk); req_i[1] = 1'b1; req_i[6] = 1'b1;
        @(negedge clk); req_i[1] = 1'b0; req_i[6] = 1'b0;
        wait_cyc(12);
        check("R9 two units", wr_cnt - base, 2);
        check("R9 lower channel first", 32'(wr_log[base % 256]), 32'h340);
        check("R9 higher channel second", 32'(wr_log[(base + 1) % 256]), 32'h350);
    endtask

    task automatic t_pause();
        int base, n1;
        setup(0, 'h1C0, 'h380, 12, 0, ctl(0, 2, 1, 1));
        base = wr_cnt;
        pulse(0);
        wait_cyc(5);
        pause_i = 1'b1;
        wait_cyc(4);
        n1 = wr_cnt - base;
        wait_cyc(20);
        check("R10 frozen while paused", wr_cnt - base, n1);
        check("R10 paused mid-burst", 32'(n1 < 12), 1);
        pause_i = 1'b0;
        wait_cyc(40);
        check("R10 resumes to full count", wr_cnt - base, 12);
        check("R10 data intact", cmp_bytes('h1C0, 'h380, 12), 0);
        check("R10 done", 32'(done_o[0]), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_step();
        t_block();
        t_burst();
        t_fixed();
        t_cont();
        t_prio();
        t_pause();
        check("R11 write always follows read", seq_err, 0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        finish_run();
    end

endmodule